// File: doc/BRIEF.md
# Jitter-Attenuator Reference Selector

This control block picks the timing reference that a jitter-attenuator oscillator locks to. It can follow any one of four recovered line clocks, an external synchronisation clock (SYNC) running at a configured rate, or nothing at all. In the last case the oscillator runs free and is held at its nominal centre frequency. The oscillator, phase detector and loop filter sit outside this block and act on its outputs.

The raw SYNC and line clocks are sampled by a fast system clock. Each one passes through a two-flop synchroniser and an activity monitor. A clock counts as present while its latest edge is no older than a per-rate timeout.

The decision logic is a three-state machine with the states FREE, LINE and SYNC. It evaluates a next state on every system clock:
- FREE→LINE when the block is in slave operation with no active fallback and the chosen line clock is live.
- FREE→SYNC and LINE→SYNC when master operation or fallback is active, SYNC is live and the rate field is valid.
- LINE→FREE and SYNC→FREE when the reference needed is missing.
- SYNC→LINE when slave operation returns with no fault.

Every change of the selected-source code raises a one-cycle pulse.

Top module: `ja_ref_select`

## Requirements
- R1: After reset the outputs are: selected source 7 (free-run), centre command 1, rate class 3 (none) and change pulse 0.
- R2: In slave operation (mode_master=0) with no loss flag, the selected source equals line_sel (0 to 3), provided that line's clock is live. The centre command is then 0 and the rate class is 3.
- R3: In slave operation, a high los_i or tcl_i with fb_dis=0 moves the selection to the SYNC rules. A live SYNC gives source 4.
- R4: With fb_dis=1, a loss flag in slave operation leaves the line selected and never selects SYNC.
- R5: In master operation with a live SYNC and sync_freq of 00 (2.048 MHz), 01 (1.544 MHz) or 10 (8 kHz), the source is 4 and the rate class equals sync_freq. The line clocks have no effect in this case.
- R6: In master operation with SYNC held static high, the source is 7 and the centre command is 1.
- R7: While SYNC is followed, the centre command is 1 when cen_dis=0 and 0 when cen_dis=1.
- R8: A sync_freq value of 11 is reserved. It gives source 7 with centre 1, even when SYNC is live.
- R9: After a fallback from slave operation with SYNC static, the source is 7 and the centre command is 1.
- R10: A clock with no edge inside its timeout is absent. A live SYNC that stops stays selected for a short time, then is dropped to free-run. A missing selected line in slave operation gives free-run.
- R11: chg_o is high for exactly one cycle each time src_o changes, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low reset |
| mode_master | input | 1 | 1 = master operation, 0 = slave operation |
| line_sel | input | 2 | Line chosen in slave operation |
| los_i | input | 1 | Receive loss of signal |
| tcl_i | input | 1 | Transmit clock lost |
| fb_dis | input | 1 | Suppresses the fallback to SYNC |
| cen_dis | input | 1 | Removes the centre command while SYNC is followed |
| sync_freq | input | 2 | Expected SYNC rate: 00 = 2.048 MHz, 01 = 1.544 MHz, 10 = 8 kHz, 11 = reserved |
| sync_in | input | 1 | Raw SYNC clock |
| line_clk | input | 4 | Raw recovered line clocks |
| src_o | output | 3 | Selected source: 0 to 3 = line, 4 = SYNC, 7 = free-run |
| centre_o | output | 1 | Command to hold the oscillator at its nominal centre |
| freq_o | output | 2 | Rate class of the reference followed (3 = none) |
| chg_o | output | 1 | One-cycle pulse on each source change |

## Verification
The selection is driven with a table of patterns that combine mode, line choice, loss flags, fallback-disable, centring-disable, rate field, SYNC activity and line activity. Together they separate:
- line following from fallback to SYNC;
- fallback from a held line;
- a live SYNC from a static one;
- the three valid rates from the reserved one.

Directed tests then cover three further cases:
- a SYNC clock that stops, to confirm the timeout holds the selection briefly before dropping it;
- a change of line, which must give exactly one pulse;
- steady inputs, which must give no pulse.

// File: rtl/ja_sel_pkg.sv
`timescale 1ns/1ps
package ja_sel_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_LINE = 2'd1,
        ST_SYNC = 2'd2
    } sel_st_e;

    localparam logic [2:0] SRC_SYNC = 3'd4;
    localparam logic [2:0] SRC_FREE = 3'd7;
    localparam logic [1:0] FQ_2M048 = 2'b00;
    localparam logic [1:0] FQ_1M544 = 2'b01;
    localparam logic [1:0] FQ_8K    = 2'b10;
    localparam logic [1:0] FQ_NONE  = 2'b11;
endpackage

// File: rtl/clk_presence_mon.sv
`timescale 1ns/1ps
module clk_presence_mon #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw,
    input  logic [CW-1:0] limit,
    output logic          present
);
    logic [2:0]    sh_q;
    logic [CW-1:0] age_q;
    logic          edge_seen;

    assign edge_seen = sh_q[2] ^ sh_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= 3'b111;
            age_q <= '1;
        end else begin
            sh_q <= {sh_q[1:0], raw};
            if (edge_seen)
                age_q <= '0;
            else if (age_q < limit)
                age_q <= age_q + 1'b1;
        end
    end

    assign present = age_q < limit;

    // R10
    edge_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> present);
endmodule

// File: rtl/ref_sel_fsm.sv
`timescale 1ns/1ps
module ref_sel_fsm
    import ja_sel_pkg::*;
#(
    parameter int NL = 4,
    localparam int SW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_master,
    input  logic [SW-1:0] line_sel,
    input  logic          fault,
    input  logic          fb_dis,
    input  logic          cen_dis,
    input  logic [1:0]    sync_freq,
    input  logic          sync_ok,
    input  logic [NL-1:0] line_ok,
    output logic [2:0]    src_o,
    output logic          centre_o,
    output logic [1:0]    freq_o,
    output logic          chg_o
);
    sel_st_e    st_q, st_d;
    logic       use_line;
    logic [2:0] src_d;

    always_comb begin
        use_line = !mode_master && !(fault && !fb_dis);
        st_d = ST_FREE;
        if (use_line) begin
            if (line_ok[line_sel]) st_d = ST_LINE;
        end else if (sync_ok && sync_freq != FQ_NONE) begin
            st_d = ST_SYNC;
        end
        unique case (st_d)
            ST_LINE: src_d = {{(3-SW){1'b0}}, line_sel};
            ST_SYNC: src_d = SRC_SYNC;
            default: src_d = SRC_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_FREE;
        else        st_q <= st_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_o    <= SRC_FREE;
            chg_o    <= 1'b0;
            centre_o <= 1'b1;
            freq_o   <= FQ_NONE;
        end else begin
            src_o    <= src_d;
            chg_o    <= src_d != src_o;
            centre_o <= (st_d == ST_FREE) || (st_d == ST_SYNC && !cen_dis);
            freq_o   <= (st_d == ST_SYNC) ? sync_freq : FQ_NONE;
        end
    end

    // R11
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o == (src_o != $past(src_o)));
    // R8
    free_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FREE) |-> (centre_o && src_o == SRC_FREE && freq_o == FQ_NONE));
    // R5
    sync_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SYNC) |-> (src_o == SRC_SYNC && freq_o != FQ_NONE));
    // R4
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && fb_dis) |=> (src_o != SRC_SYNC));
    // R7
    centre_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_d == ST_SYNC) |=> (centre_o == !$past(cen_dis)));
endmodule

// File: rtl/ja_ref_select.sv
`timescale 1ns/1ps
module ja_ref_select
    import ja_sel_pkg::*;
#(
    parameter int NL      = 4,
    parameter int TMO_LN  = 96,
    parameter int TMO_2M  = 96,
    parameter int TMO_1M5 = 128,
    parameter int TMO_8K  = 20000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_master,
    input  logic [1:0]    line_sel,
    input  logic          los_i,
    input  logic          tcl_i,
    input  logic          fb_dis,
    input  logic          cen_dis,
    input  logic [1:0]    sync_freq,
    input  logic          sync_in,
    input  logic [3:0]    line_clk,
    output logic [2:0]    src_o,
    output logic          centre_o,
    output logic [1:0]    freq_o,
    output logic          chg_o
);
    localparam int M1   = (TMO_LN > TMO_2M) ? TMO_LN : TMO_2M;
    localparam int M2   = (TMO_1M5 > TMO_8K) ? TMO_1M5 : TMO_8K;
    localparam int MAXL = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXL + 1);

    logic [CW-1:0] sync_lim;
    logic          sync_ok;
    logic [NL-1:0] line_ok;

    always_comb begin
        unique case (sync_freq)
            FQ_1M544: sync_lim = CW'(TMO_1M5);
            FQ_8K:    sync_lim = CW'(TMO_8K);
            default:  sync_lim = CW'(TMO_2M);
        endcase
    end

    clk_presence_mon #(.CW(CW)) u_sync_mon (
        .clk(clk), .rst_n(rst_n), .raw(sync_in),
        .limit(sync_lim), .present(sync_ok)
    );

    for (genvar g = 0; g < NL; g++) begin : g_line
        clk_presence_mon #(.CW(CW)) u_line_mon (
            .clk(clk), .rst_n(rst_n), .raw(line_clk[g]),
            .limit(CW'(TMO_LN)), .present(line_ok[g])
        );
    end

    ref_sel_fsm #(.NL(NL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
        .line_sel(line_sel), .fault(los_i | tcl_i), .fb_dis(fb_dis),
        .cen_dis(cen_dis), .sync_freq(sync_freq), .sync_ok(sync_ok),
        .line_ok(line_ok), .src_o(src_o), .centre_o(centre_o),
        .freq_o(freq_o), .chg_o(chg_o)
    );

    // R2
    src_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_o <= 3'd4) || (src_o == 3'd7));
endmodule

// File: tb/sim_ja_ref_select.sv
`timescale 1ns/1ps
module sim_ja_ref_select;
    typedef struct packed {
        logic       mm;
        logic [1:0] sel;
        logic       los;
        logic       tcl;
        logic       fbd;
        logic       cend;
        logic [1:0] frq;
        logic       syn_en;
        logic [3:0] ln_en;
        logic [2:0] e_src;
        logic       e_cen;
        logic [1:0] e_frq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 4'hF, 3'd0, 1'b0, 2'd3}, // R2
        '{1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 4'hF, 3'd2, 1'b0, 2'd3}, // R2
        '{1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 4'h7, 3'd7, 1'b1, 2'd3}, // R10
        '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 4'hF, 3'd4, 1'b1, 2'd0}, // R3
        '{1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 4'hF, 3'd4, 1'b0, 2'd0}, // R3 R7
        '{1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 4'hF, 3'd1, 1'b0, 2'd3}, // R4
        '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'hF, 3'd7, 1'b1, 2'd3}, // R9
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 4'hF, 3'd4, 1'b1, 2'd1}, // R5
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 4'hF, 3'd4, 1'b1, 2'd2}, // R5
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 4'hF, 3'd4, 1'b0, 2'd2}, // R7
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'hF, 3'd7, 1'b1, 2'd3}, // R6
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 4'hF, 3'd7, 1'b1, 2'd3}, // R8
        '{1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 4'h0, 3'd4, 1'b1, 2'd0}  // R5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_master = 1'b0;
    logic [1:0] line_sel = 2'd0;
    logic       los_i = 1'b0, tcl_i = 1'b0, fb_dis = 1'b0, cen_dis = 1'b0;
    logic [1:0] sync_freq = 2'b00;
    logic       sync_in = 1'b1;
    logic [3:0] line_clk = 4'hF;
    logic [2:0] src_o;
    logic       centre_o, chg_o;
    logic [1:0] freq_o;

    logic       syn_en = 1'b0;
    logic [3:0] ln_en = 4'h0;
    int         tick = 0;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ja_ref_select #(.TMO_LN(16), .TMO_2M(16), .TMO_1M5(24), .TMO_8K(64)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .line_sel(line_sel),
        .los_i(los_i), .tcl_i(tcl_i), .fb_dis(fb_dis), .cen_dis(cen_dis),
        .sync_freq(sync_freq), .sync_in(sync_in), .line_clk(line_clk),
        .src_o(src_o), .centre_o(centre_o), .freq_o(freq_o), .chg_o(chg_o)
    );

    // test clock sources: one edge every three system cycles, high when idle
    always @(negedge clk) begin
        tick <= (tick == 2) ? 0 : tick + 1;
        if (tick == 0) begin
            sync_in  <= syn_en ? ~sync_in : 1'b1;
            line_clk <= (line_clk ^ ln_en) | ~ln_en;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic apply(input vec_t v);
        mode_master = v.mm; line_sel = v.sel; los_i = v.los; tcl_i = v.tcl;
        fb_dis = v.fbd; cen_dis = v.cend; sync_freq = v.frq;
        syn_en = v.syn_en; ln_en = v.ln_en;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        waitc(3);
        // R1 reset state
        chk("R1", {src_o, centre_o, freq_o, chg_o}, {3'd7, 1'b1, 2'd3, 1'b0});
        rst_n = 1'b1;
        waitc(5);
        chk("R1 after release", {src_o, centre_o, freq_o, chg_o}, {3'd7, 1'b1, 2'd3, 1'b0});

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k]);
            waitc(150);
            chk($sformatf("vector %0d", k), {src_o, centre_o, freq_o},
                {VEC[k].e_src, VEC[k].e_cen, VEC[k].e_frq});
        end

        // R10: SYNC stops, selection holds briefly, then drops
        apply(VEC[7]);
        sync_freq = 2'b00;
        waitc(100);
        chk("R10 live", src_o, 3'd4);
        syn_en = 1'b0;
        waitc(10);
        chk("R10 within timeout", src_o, 3'd4);
        waitc(40);
        chk("R10 after timeout", {src_o, centre_o}, {3'd7, 1'b1});

        // R11: one pulse for one change, none while steady
        apply(VEC[0]);
        waitc(100);
        begin
            int pulses = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (chg_o) pulses++;
            end
            chk("R11 steady", pulses, 0);
            line_sel = 2'd1;
            pulses = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (chg_o) pulses++;
            end
            chk("R11 one change", pulses, 1);
            chk("R11 new source", src_o, 3'd1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule